// File: doc/BRIEF.md
# Pulse Accumulator with Interrupt Flags

This block counts events from a single external input into a 16-bit accumulator made of two cascaded 8-bit count bytes. In event mode, every active edge on the input adds one to the count. In gated mode, the same input acts as a gate instead. While the gate is active, the block counts cycles in which a prescaled tick enable is high. The input passes through a two-stage synchroniser before edge detection. One control bit selects the active edge in event mode and the gate polarity in gated mode.

A two-bit flag register records two conditions: an overflow of the accumulator, and an input event. The input event is each active edge in event mode, or the end of the gate in gated mode. Each flag, ANDed with its own enable, drives a level interrupt output. Flags clear in one of two ways. By default, software writes a one to the flag. In a fast-clear mode, software instead accesses the count bytes. A saturation option holds the upper byte at its maximum instead of letting it wrap.

A small register port reads and writes the flag register and both count bytes. Read data is combinational from the select.

Top module: `pulse_accum`

## Requirements
- R1: After reset, both count bytes and both flags are zero, `reg_rdata` reads zero for every select, and both interrupt outputs are low.
- R2: In event mode (`gated_mode`=0) with `acc_en`=1, each active edge of `pin_in` increments the 16-bit count {upper, lower} by one. The active edge is rising when `edge_sel`=0 and falling when `edge_sel`=1. The new count is visible from the third rising clock edge after the pin changes.
- R3: In event mode, each active edge sets the input flag (flag register bit 0).
- R4: In gated mode (`gated_mode`=1), the count increments once per clock cycle in which `tick_en` is high and the synchronised gate is active. The gate is active when the pin is high for `edge_sel`=0, or low for `edge_sel`=1. Ticks while the gate is inactive do not count.
- R5: In gated mode, the input flag is set only by the trailing edge of the gate, never by its leading edge.
- R6: A carry out of the lower byte increments the upper byte. When the count wraps from 0xFFFF to 0x0000, the overflow flag (flag register bit 1) is set.
- R7: With `sat_mode`=1, a carry into an upper byte already at 0xFF leaves it at 0xFF. The lower byte still wraps, and the overflow flag is set.
- R8: With `fast_clr`=0, writing the flag register clears each flag whose data bit is one and leaves a flag unchanged where the data bit is zero.
- R9: With `fast_clr`=1, writes to the flag register clear nothing. Any read or write of a count byte clears the overflow flag, and a write of a count byte clears the input flag.
- R10: When a flag-set event and a clear of the same flag fall in one cycle, the flag ends set.
- R11: Select encoding is 0 for the flag register, 1 for the upper count byte, 2 for the lower count byte, and 3 reads zero. In the flag register, bit 1 is overflow, bit 0 is input, and bits 7 to 2 read zero.
- R12: `irq_ovf` equals the overflow flag AND `ovf_ie`, and `irq_edge` equals the input flag AND `edge_ie`. Flags are set whatever the enables are.
- R13: With `acc_en`=0, input activity changes neither the count nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Accumulator enable |
| gated_mode | input | 1 | 1 selects gated time accumulation, 0 selects event counting |
| edge_sel | input | 1 | 0: rising edge or active-high gate; 1: falling edge or active-low gate |
| sat_mode | input | 1 | Upper byte saturates at 0xFF |
| fast_clr | input | 1 | Flags clear by count access instead of write-one |
| ovf_ie | input | 1 | Overflow interrupt enable |
| edge_ie | input | 1 | Input interrupt enable |
| pin_in | input | 1 | Asynchronous accumulator input |
| tick_en | input | 1 | Prescaled clock enable counted in gated mode |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_edge | output | 1 | Input interrupt request |

## Verification
A wrong synchroniser depth or edge decode shows up three clock cycles after a pin change. The count then reads off by one, or moves on the wrong polarity. A faulty carry or saturation path only appears at the 0xFF and 0xFFFF boundaries, so the bench preloads the count bytes right below them. A broken flag-clear path leaves a stale bit in the flag register, or a level on an interrupt output, on the first read after the clear. That stale value persists until the next clear.

// File: rtl/pa_pkg.sv
package pa_pkg;
  typedef enum logic [1:0] {
    SEL_FLAGS  = 2'd0,
    SEL_CNT_HI = 2'd1,
    SEL_CNT_LO = 2'd2,
    SEL_NONE   = 2'd3
  } pa_sel_e;

  localparam int unsigned FLAG_OVF_BIT  = 1;
  localparam int unsigned FLAG_EDGE_BIT = 0;
endpackage

// File: rtl/pa_input_cond.sv
module pa_input_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  input  logic invert,
  output logic level_act,
  output logic lead_evt,
  output logic trail_evt
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic prev_q, prev_d;
  logic synced, rise, fall;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      assign sync_d = pin_raw;
    end else begin : g_chain
      assign sync_d = {sync_q[SYNC_STAGES-2:0], pin_raw};
    end
  endgenerate

  assign synced = sync_q[SYNC_STAGES-1];
  assign prev_d = synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  always_comb begin
    rise      = synced & ~prev_q;
    fall      = ~synced & prev_q;
    level_act = synced ^ invert;
    lead_evt  = invert ? fall : rise;
    trail_evt = invert ? rise : fall;
  end
endmodule

// File: rtl/pa_count.sv
module pa_count #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_evt,
  input  logic              sat_mode,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic              ovf_evt
);
  localparam logic [BYTE_W-1:0] BYTE_MAX = {BYTE_W{1'b1}};
  localparam logic [BYTE_W-1:0] BYTE_ONE = {{(BYTE_W-1){1'b0}}, 1'b1};

  logic [BYTE_W-1:0] hi_q, lo_q, hi_d, lo_d;
  logic evt_eff, carry, hi_full;

  always_comb begin
    evt_eff = cnt_evt & ~(wr_hi | wr_lo);
    carry   = evt_eff & (lo_q == BYTE_MAX);
    hi_full = (hi_q == BYTE_MAX);
    ovf_evt = carry & hi_full;
    lo_d    = lo_q;
    hi_d    = hi_q;
    if (evt_eff) lo_d = lo_q + BYTE_ONE;
    if (carry && !(hi_full && sat_mode)) hi_d = hi_q + BYTE_ONE;
    if (wr_lo) lo_d = wdata;
    if (wr_hi) hi_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign cnt_hi = hi_q;
  assign cnt_lo = lo_q;
endmodule

// File: rtl/pa_flags.sv
module pa_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_set,
  input  logic edge_set,
  input  logic flag_wr,
  input  logic [1:0] wbits,
  input  logic fast_clr,
  input  logic cnt_access,
  input  logic cnt_write,
  output logic ovf_q,
  output logic edge_q
);
  logic ovf_d, edge_d, ovf_clr, edge_clr;

  always_comb begin
    ovf_clr  = fast_clr ? cnt_access : (flag_wr & wbits[1]);
    edge_clr = fast_clr ? cnt_write  : (flag_wr & wbits[0]);
    ovf_d    = ovf_set  ? 1'b1 : (ovf_clr  ? 1'b0 : ovf_q);
    edge_d   = edge_set ? 1'b1 : (edge_clr ? 1'b0 : edge_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      ovf_q  <= ovf_d;
      edge_q <= edge_d;
    end
  end
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
  import pa_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              gated_mode,
  input  logic              edge_sel,
  input  logic              sat_mode,
  input  logic              fast_clr,
  input  logic              ovf_ie,
  input  logic              edge_ie,
  input  logic              pin_in,
  input  logic              tick_en,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq_ovf,
  output logic              irq_edge
);
  logic level_act, lead_evt, trail_evt;
  logic cnt_evt, edge_set, ovf_evt;
  logic wr_hi, wr_lo, flag_wr, cnt_sel, cnt_access, cnt_write;
  logic [BYTE_W-1:0] cnt_hi, cnt_lo;
  logic flag_ovf, flag_edge;

  pa_input_cond #(.SYNC_STAGES(SYNC_STAGES)) u_in (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_in), .invert(edge_sel),
    .level_act(level_act), .lead_evt(lead_evt), .trail_evt(trail_evt)
  );

  always_comb begin
    cnt_evt    = acc_en & (gated_mode ? (level_act & tick_en) : lead_evt);
    edge_set   = acc_en & (gated_mode ? trail_evt : lead_evt);
    flag_wr    = reg_wr & (reg_sel == SEL_FLAGS);
    wr_hi      = reg_wr & (reg_sel == SEL_CNT_HI);
    wr_lo      = reg_wr & (reg_sel == SEL_CNT_LO);
    cnt_sel    = (reg_sel == SEL_CNT_HI) | (reg_sel == SEL_CNT_LO);
    cnt_access = (reg_wr | reg_rd) & cnt_sel;
    cnt_write  = reg_wr & cnt_sel;
  end

  pa_count #(.BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_evt(cnt_evt), .sat_mode(sat_mode),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wdata(reg_wdata),
    .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .ovf_evt(ovf_evt)
  );

  pa_flags u_flg (
    .clk(clk), .rst_n(rst_n), .ovf_set(ovf_evt), .edge_set(edge_set),
    .flag_wr(flag_wr), .wbits(reg_wdata[1:0]), .fast_clr(fast_clr),
    .cnt_access(cnt_access), .cnt_write(cnt_write),
    .ovf_q(flag_ovf), .edge_q(flag_edge)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_FLAGS: begin
        reg_rdata[FLAG_OVF_BIT]  = flag_ovf;
        reg_rdata[FLAG_EDGE_BIT] = flag_edge;
      end
      SEL_CNT_HI: reg_rdata = cnt_hi;
      SEL_CNT_LO: reg_rdata = cnt_lo;
      default:    reg_rdata = '0;
    endcase
    irq_ovf  = flag_ovf & ovf_ie;
    irq_edge = flag_edge & edge_ie;
  end
endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              sat_mode,
  input logic              fast_clr,
  input logic              edge_ie,
  input logic [1:0]        reg_sel,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [BYTE_W-1:0] reg_wdata,
  input logic [BYTE_W-1:0] reg_rdata,
  input logic              irq_edge,
  input logic [BYTE_W-1:0] cnt_hi,
  input logic [BYTE_W-1:0] cnt_lo,
  input logic              flag_ovf,
  input logic              flag_edge
);
  logic touch_cnt, write_cnt;
  assign touch_cnt = (reg_wr | reg_rd) & ((reg_sel == 2'd1) | (reg_sel == 2'd2));
  assign write_cnt = reg_wr & ((reg_sel == 2'd1) | (reg_sel == 2'd2));

  p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd0) |-> (reg_rdata[BYTE_W-1:2] == '0));

  p_irq_needs_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_edge |-> edge_ie);

  p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_mode && (cnt_hi == {BYTE_W{1'b1}}) && !(reg_wr && reg_sel == 2'd1))
    |=> (cnt_hi == {BYTE_W{1'b1}}));

  p_idle_stable_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en && !write_cnt) |=> $stable({cnt_hi, cnt_lo}));

  p_fast_keeps_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_clr && flag_ovf && !touch_cnt) |=> flag_ovf);

  p_w1c_zero_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_clr && flag_edge && !(reg_wr && reg_sel == 2'd0 && reg_wdata[0])) |=> flag_edge);
endmodule

bind pulse_accum pa_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .sat_mode(sat_mode),
  .fast_clr(fast_clr), .edge_ie(edge_ie), .reg_sel(reg_sel),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .irq_edge(irq_edge), .cnt_hi(cnt_hi),
  .cnt_lo(cnt_lo), .flag_ovf(flag_ovf), .flag_edge(flag_edge)
);

// File: tb/pulse_accum_test.sv
`timescale 1ns/1ps
module pulse_accum_test;
  logic clk = 1'b0;
  logic rst_n, acc_en, gated_mode, edge_sel, sat_mode, fast_clr, ovf_ie, edge_ie;
  logic pin_in, tick_en, reg_wr, reg_rd, irq_ovf, irq_edge;
  logic [1:0] reg_sel;
  logic [7:0] reg_wdata, reg_rdata;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pulse_accum uut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .gated_mode(gated_mode),
    .edge_sel(edge_sel), .sat_mode(sat_mode), .fast_clr(fast_clr),
    .ovf_ie(ovf_ie), .edge_ie(edge_ie), .pin_in(pin_in), .tick_en(tick_en),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_ovf(irq_ovf), .irq_edge(irq_edge)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_rd = 1'b1; #2 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic pulse(input logic idle);
    @(negedge clk); pin_in = ~idle;
    repeat (4) @(negedge clk);
    pin_in = idle;
    repeat (4) @(negedge clk);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
    wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'h03);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, h;
    int total;
    rst_n = 1'b0; acc_en = 0; gated_mode = 0; edge_sel = 0; sat_mode = 0;
    fast_clr = 0; ovf_ie = 0; edge_ie = 0; pin_in = 0; tick_en = 0;
    reg_sel = 0; reg_wr = 0; reg_rd = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int s = 0; s < 4; s++) begin
      rd(s[1:0], d); check("R1 reset read", d, 0);
    end
    check("R1 irq_ovf", irq_ovf, 0);
    check("R1 irq_edge", irq_edge, 0);

    acc_en = 1;
    for (int pol = 0; pol < 2; pol++) begin
      edge_sel = pol[0]; pin_in = pol[0];
      settle();
      for (int n = 1; n <= 12; n++) begin
        pulse(pol[0]);
        rd(2'd2, d); check("R2 event count lo", d, n);
        rd(2'd1, h); check("R2 event count hi", h, 0);
        rd(2'd0, d); check("R3 edge flag", d, 1);
        wr(2'd0, 8'h01);
      end
    end

    gated_mode = 1;
    for (int pol = 0; pol < 2; pol++) begin
      edge_sel = pol[0]; pin_in = pol[0];
      settle();
      @(negedge clk); tick_en = 1;
      repeat (5) @(negedge clk);
      tick_en = 0;
      rd(2'd2, d); check("R4 inactive gate", d, 0);
      total = 0;
      for (int g = 1; g <= 8; g++) begin
        @(negedge clk); pin_in = ~pol[0];
        repeat (4) @(negedge clk);
        rd(2'd0, d); check("R5 no flag on lead", d, 0);
        @(negedge clk); tick_en = 1;
        repeat (g) @(negedge clk);
        tick_en = 0;
        total += g;
        pin_in = pol[0];
        repeat (4) @(negedge clk);
        rd(2'd2, d); check("R4 gated count", d, total);
        rd(2'd0, d); check("R5 flag on trail", d, 1);
        wr(2'd0, 8'h01);
      end
    end

    gated_mode = 0; edge_sel = 0; pin_in = 0;
    settle();
    acc_en = 0;
    pulse(1'b0); pulse(1'b0);
    rd(2'd2, d); check("R13 disabled count", d, 0);
    rd(2'd0, d); check("R13 disabled flags", d, 0);
    acc_en = 1;

    wr(2'd1, 8'hFF); wr(2'd2, 8'hFE);
    pulse(1'b0);
    rd(2'd0, d); check("R6 no ovf at FFFF", d & 2, 0);
    rd(2'd1, h); check("R6 hi at FFFF", h, 8'hFF);
    wr(2'd1, 8'h12); wr(2'd2, 8'hFF);
    pulse(1'b0);
    rd(2'd1, h); check("R6 carry into hi", h, 8'h13);
    rd(2'd0, d); check("R6 no ovf on carry", d & 2, 0);
    wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
    pulse(1'b0);
    rd(2'd1, h); rd(2'd2, d); check("R6 wrap count", {h, d}, 0);
    rd(2'd0, d); check("R6 ovf set", d & 2, 2);

    check("R12 ovf no irq when disabled", irq_ovf, 0);
    ovf_ie = 1; edge_ie = 1; #1;
    check("R12 irq_ovf", irq_ovf, 1);
    check("R12 irq_edge", irq_edge, 1);

    wr(2'd0, 8'h00);
    rd(2'd0, d); check("R8 write zero keeps", d, 3);
    wr(2'd0, 8'h02);
    rd(2'd0, d); check("R8 clear ovf only", d, 1);
    check("R12 irq_ovf low", irq_ovf, 0);
    wr(2'd0, 8'h01);
    rd(2'd0, d); check("R8 clear edge", d, 0);

    sat_mode = 1;
    wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
    pulse(1'b0);
    rd(2'd1, h); rd(2'd2, d); check("R7 saturate", {h, d}, 16'hFF00);
    rd(2'd0, d); check("R7 ovf set", d, 3);
    pulse(1'b0);
    rd(2'd1, h); rd(2'd2, d); check("R7 count on", {h, d}, 16'hFF01);
    sat_mode = 0;

    fast_clr = 1;
    wr(2'd0, 8'h03);
    rd(2'd0, d); check("R9 w1c ignored", d, 3);
    rd(2'd1, h);
    rd(2'd0, d); check("R9 read clears ovf", d, 1);
    wr(2'd2, 8'h40);
    rd(2'd0, d); check("R9 write clears edge", d, 0);
    fast_clr = 0;

    pulse(1'b0);
    @(negedge clk); pin_in = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_sel = 2'd0; reg_wdata = 8'h01; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    repeat (3) @(negedge clk);
    rd(2'd0, d); check("R10 set wins over clear", d & 1, 1);
    rd(2'd3, d); check("R11 select 3 zero", d, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule